// File: doc/BRIEF.md
# Branch-and-exchange fetch sequencer

This block drives the instruction-fetch bus of a core that runs either a 32-bit or a 16-bit instruction stream while it executes a branch that may also switch the stream width. A one-cycle trigger carries three things: the current program counter, the register operand that names the target, and the current mode bit. The block then runs three bus cycles. The first is an unconditional prefetch from the old stream, and its data is discarded. The second and third are opcode fetches from the new target, made with the width and access size of the newly selected mode.

When the sequence ends, the block goes idle. It then presents the next sequential fetch address and the new mode, so the following fetch stage can continue from there. Bit 0 of the register operand selects the new mode. The target address is the operand with its low bit cleared. When the new mode is the 32-bit mode, bit 1 is cleared as well.

Top module: `bx_fetch_seq`

## Requirements
- R1: A trigger seen on a rising edge while idle starts the sequence. `busy` is high for exactly the three following cycles and low after them.
- R2: In bus cycle 1, `fetch_addr` is the old PC plus twice the old width. `fetch_size`, `mode_out` and `fetch_seq` show the old size code, the old mode and 0.
- R3: In bus cycle 2, `fetch_addr` is the target address. `fetch_size` and `mode_out` show the new size code and the new mode, and `fetch_seq` is 1.
- R4: In bus cycle 3, `fetch_addr` is the target plus the new width. `fetch_size` and `mode_out` stay at the new values, and `fetch_seq` is 1.
- R5: The mode encodings are fixed. Mode bit 0 is the 32-bit mode, with width 4 bytes and size code 2. Mode bit 1 is the 16-bit mode, with width 2 bytes and size code 1.
- R6: The new mode is `operand[0]`. The target is `operand` with bit 0 cleared, and with bit 1 also cleared when the new mode is 0.
- R7: During the three bus cycles, `fetch_rd_n`, `fetch_req_n` and `fetch_opc_n` are all 0. While idle, all three are 1.
- R8: When idle after a sequence, `fetch_addr` shows the target plus twice the new width. `mode_out` and `fetch_size` show the new mode and its size code, and `fetch_seq` is 0.
- R9: A trigger that arrives while `busy` is high has no effect on the addresses, codes or timing of the running sequence, or on the idle state that follows it.
- R10: A synchronous active-high reset returns the block to idle, with mode 0, size code 2, `fetch_addr` 0, `fetch_seq` 0 and all strobes at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle trigger for the branch sequence |
| cur_pc | input | AW | Program counter at the time of the trigger |
| operand | input | AW | Register operand: target address and new mode in bit 0 |
| cur_mode | input | 1 | Mode in force at the time of the trigger |
| busy | output | 1 | High during the three bus cycles |
| fetch_addr | output | AW | Fetch byte address |
| fetch_size | output | 2 | Access size code |
| fetch_seq | output | 1 | Sequential-access flag |
| fetch_rd_n | output | 1 | Read/write strobe, 0 means read |
| fetch_req_n | output | 1 | Memory request, active low |
| fetch_opc_n | output | 1 | Opcode fetch, active low |
| mode_out | output | 1 | Mode bit that goes with the current bus cycle |

## Verification
A wrong phase count or a missed accept shows at the ports within one cycle. The strobes, `busy` and the sequential flag would then rise or fall on the wrong edge. A wrongly latched old or new mode shows in the same cycle as a size code or address step that does not match `mode_out`. A bad target mask shows in cycle 2 as low address bits that are not aligned to the new width. The bench sweeps all four combinations of old and new mode over several PC and operand patterns, including values at the top of the address range that wrap. It computes each cycle's address, size code, flag and mode arithmetically. It also fires extra triggers mid-sequence.

// File: rtl/bx_fetch_seq.sv
module bx_fetch_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] operand,
  input  logic          cur_mode,
  output logic          busy,
  output logic [AW-1:0] fetch_addr,
  output logic [1:0]    fetch_size,
  output logic          fetch_seq,
  output logic          fetch_rd_n,
  output logic          fetch_req_n,
  output logic          fetch_opc_n,
  output logic          mode_out
);

  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] PH_IDLE = 2'd0;
  localparam logic [1:0] PH_LAST = 2'd3;

  function automatic logic [AW-1:0] width_of(input logic m);
    return m ? AW'(2) : AW'(4);
  endfunction

  function automatic logic [1:0] size_of(input logic m);
    return m ? SZ_HALF : SZ_WORD;
  endfunction

  logic [1:0]    phase;
  logic [AW-1:0] pc_q, dst_q, nxt_q;
  logic          old_q, new_q, mode_q;

  wire accept = start && (phase == PH_IDLE);
  wire new_m  = operand[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      pc_q   <= '0;
      dst_q  <= '0;
      nxt_q  <= '0;
      old_q  <= 1'b0;
      new_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (accept) begin
      phase <= 2'd1;
      pc_q  <= cur_pc;
      dst_q <= operand & ~(new_m ? AW'(1) : AW'(3));
      old_q <= cur_mode;
      new_q <= new_m;
    end else if (phase == PH_LAST) begin
      phase  <= PH_IDLE;
      mode_q <= new_q;
      nxt_q  <= dst_q + (width_of(new_q) << 1);
    end else if (phase != PH_IDLE) begin
      phase <= phase + 2'd1;
    end
  end

  assign busy        = (phase != PH_IDLE);
  assign fetch_rd_n  = ~busy;
  assign fetch_req_n = ~busy;
  assign fetch_opc_n = ~busy;

  always_comb begin
    case (phase)
      2'd1: begin
        fetch_addr = pc_q + (width_of(old_q) << 1);
        fetch_size = size_of(old_q);
        fetch_seq  = 1'b0;
        mode_out   = old_q;
      end
      2'd2: begin
        fetch_addr = dst_q;
        fetch_size = size_of(new_q);
        fetch_seq  = 1'b1;
        mode_out   = new_q;
      end
      2'd3: begin
        fetch_addr = dst_q + width_of(new_q);
        fetch_size = size_of(new_q);
        fetch_seq  = 1'b1;
        mode_out   = new_q;
      end
      default: begin
        fetch_addr = nxt_q;
        fetch_size = size_of(mode_q);
        fetch_seq  = 1'b0;
        mode_out   = mode_q;
      end
    endcase
  end

  assert_start_seq_R1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy ##1 busy ##1 busy ##1 !busy);

  assert_first_nonseq_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> !fetch_seq && !fetch_req_n);

  assert_step_width_R4: assert property (@(posedge clk) disable iff (rst)
    (fetch_seq && $past(fetch_seq)) |->
      fetch_addr == $past(fetch_addr) + (mode_out ? AW'(2) : AW'(4)));

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (fetch_seq && $past(fetch_seq)) |-> $stable(mode_out) && $stable(fetch_size));

  assert_size_code_R5: assert property (@(posedge clk) disable iff (rst)
    fetch_size == (mode_out ? 2'd1 : 2'd2));

  assert_align_R6: assert property (@(posedge clk) disable iff (rst)
    (fetch_seq && !$past(fetch_seq)) |-> fetch_addr[0] == 1'b0 && (mode_out || fetch_addr[1] == 1'b0));

  assert_strobes_R7: assert property (@(posedge clk) disable iff (rst)
    (fetch_req_n == fetch_rd_n) && (fetch_req_n == fetch_opc_n));

  assert_resume_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> fetch_addr == $past(fetch_addr) + (mode_out ? AW'(2) : AW'(4))
                    && $stable(mode_out) && !fetch_seq);

endmodule

// File: tb/bx_fetch_seq_tb.sv
module bx_fetch_seq_tb;
  localparam int AW = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, cur_mode = 1'b0;
  logic [AW-1:0] cur_pc = '0, operand = '0;
  logic busy, fetch_seq, fetch_rd_n, fetch_req_n, fetch_opc_n, mode_out;
  logic [AW-1:0] fetch_addr;
  logic [1:0] fetch_size;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bx_fetch_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cur_pc(cur_pc), .operand(operand),
    .cur_mode(cur_mode), .busy(busy), .fetch_addr(fetch_addr), .fetch_size(fetch_size),
    .fetch_seq(fetch_seq), .fetch_rd_n(fetch_rd_n), .fetch_req_n(fetch_req_n),
    .fetch_opc_n(fetch_opc_n), .mode_out(mode_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] w_of(input logic m);
    return m ? AW'(2) : AW'(4);
  endfunction

  function automatic logic [1:0] sz_of(input logic m);
    return m ? 2'd1 : 2'd2;
  endfunction

  task automatic check_bus(input string req, input logic [AW-1:0] a, input logic m,
                           input logic sq, input logic bz);
    check({req, " addr"}, 64'(fetch_addr), 64'(a));
    check({req, " size"}, 64'(fetch_size), 64'(sz_of(m)));
    check({req, " mode"}, 64'(mode_out), 64'(m));
    check({req, " seq"}, 64'(fetch_seq), 64'(sq));
    check({req, " busy"}, 64'(busy), 64'(bz));
    check({req, " R7 strobes"}, 64'({fetch_rd_n, fetch_req_n, fetch_opc_n}), bz ? 64'd0 : 64'd7);
  endtask

  task automatic run_bx(input logic [AW-1:0] pc, input logic [AW-1:0] op,
                        input logic om, input bit noise);
    logic nm;
    logic [AW-1:0] dst;
    nm  = op[0];
    dst = op & ~(nm ? AW'(1) : AW'(3));
    start = 1'b1; cur_pc = pc; operand = op; cur_mode = om;
    @(negedge clk);
    start = 1'b0; cur_pc = '1; operand = ~op; cur_mode = ~om;
    check_bus("R1 R2 R5 cycle1", pc + 2 * w_of(om), om, 1'b0, 1'b1);
    if (noise) start = 1'b1;
    @(negedge clk);
    check_bus("R3 R6 R9 cycle2", dst, nm, 1'b1, 1'b1);
    @(negedge clk);
    check_bus("R4 R9 cycle3", dst + w_of(nm), nm, 1'b1, 1'b1);
    start = 1'b0;
    @(negedge clk);
    check_bus("R1 R8 R9 idle", dst + 2 * w_of(nm), nm, 1'b0, 1'b0);
  endtask

  initial begin
    logic [AW-1:0] pcs [4];
    logic [AW-1:0] ops [4];
    pcs[0] = 32'h0000_1000; pcs[1] = 32'h8000_0ABC; pcs[2] = 32'hFFFF_FFFC; pcs[3] = 32'h1234_5678;
    ops[0] = 32'h0000_2000; ops[1] = 32'h4000_0007; ops[2] = 32'hFFFF_FFFE; ops[3] = 32'hDEAD_BEEB;
    repeat (2) @(negedge clk);
    check_bus("R10 reset", '0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_bus("R10 after reset", '0, 1'b0, 1'b0, 1'b0);
    for (int om = 0; om < 2; om++)
      for (int nm = 0; nm < 2; nm++)
        for (int k = 0; k < 4; k++)
          run_bx(pcs[k], {ops[(k + om) % 4][AW-1:1], 1'(nm)}, 1'(om), (k % 2) == 1);
    @(negedge clk);
    check("R9 no late start", 64'(busy), 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule